// File: doc/BRIEF.md
# Transmit Frame Padder and FCS Appender

This block sits in a transmit path between a packet scheduler and the line side. It accepts packets one byte per beat on a ready/valid stream delimited by start and end markers. Each packet is forwarded unchanged, or it is extended with a four-byte CRC-32 frame check sequence (FCS). When padding is also selected, a short packet is extended with zero bytes up to the Ethernet minimum frame size. The packet mode is captured on the first byte of each packet, so configuration changes never split a frame.

Every transfer is checked against a programmable maximum length that counts all output bytes. An overlong packet is cut at that limit. The frame still receives its FCS if FCS insertion is on, and it is flagged with an error on its last beat. The rest of that input packet is then consumed silently. The enable input only gates the start of a packet. Two saturating counters track sent frames and sent bytes, and they freeze while the block is disabled. Single-cycle events report each sent frame and the moment each counter first saturates. The integration default for the maximum length is 14'h2422 (9250 bytes).

Top module: `txf_shaper`

## Requirements
- R1: While reset is high and in the first cycle after it, out_valid, frame_cnt, byte_cnt and all three event outputs are 0.
- R2: With FCS insertion off, the input bytes of a packet appear on the output unchanged and in order. out_sop marks the first byte and out_eop marks the last. Input beats that arrive between packets without in_sop are consumed and not forwarded.
- R3: With FCS insertion on, four bytes follow the packet data. They are computed with the reflected CRC-32 (polynomial 0x04C11DB7, shift constant 0xEDB88320), starting from all ones, over data and pad bytes, and then inverted. The least significant byte is sent first, and out_eop marks the fourth byte.
- R4: With padding and FCS insertion both on, a packet with fewer than 60 data bytes is followed by zero bytes up to 60, then the FCS, for 64 bytes in total. Packets of 60 or more data bytes get no padding.
- R5: With padding on and FCS insertion off, no pad bytes are added.
- R6: A frame never exceeds cfg_max_len output bytes, FCS included. Data is cut after cfg_max_len−4 bytes (FCS on) or cfg_max_len bytes (FCS off), and out_err is 1 on that frame's last beat. The remaining input beats are consumed with no output. A packet that fits exactly is not flagged.
- R7: When cfg_enable falls, a packet in progress is finished. The next packet is held with in_ready low and no output until cfg_enable returns.
- R8: frame_cnt increments on each out_eop handshake and byte_cnt increments on every output handshake, pad and FCS bytes included. Both take effect one cycle later, and only if cfg_enable is 1 in the handshake cycle. Otherwise they hold.
- R9: Both counters stop at all ones and never wrap.
- R10: ev_frame_ovf and ev_byte_ovf pulse for exactly one cycle, in the first cycle in which the matching counter shows all ones.
- R11: ev_frame_sent pulses in the cycle after each out_eop handshake, whether or not the block is enabled.
- R12: Holding out_ready low stalls the frame at any point, including the pad and FCS bytes, without loss or duplication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Permits a new packet to start |
| cfg_pad | input | 1 | Pad short packets (only with cfg_fcs) |
| cfg_fcs | input | 1 | Append CRC-32 FCS |
| cfg_max_len | input | MAXLEN_W | Maximum output bytes per frame |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | First byte of packet |
| in_eop | input | 1 | Last byte of packet |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts beat |
| out_data | output | 8 | Output byte |
| out_sop | output | 1 | First byte of frame |
| out_eop | output | 1 | Last byte of frame |
| out_err | output | 1 | Frame was truncated (on last beat) |
| frame_cnt | output | CNT_W | Saturating sent-frame count |
| byte_cnt | output | CNT_W | Saturating sent-byte count |
| ev_frame_sent | output | 1 | Frame-sent pulse |
| ev_frame_ovf | output | 1 | Frame counter saturation pulse |
| ev_byte_ovf | output | 1 | Byte counter saturation pulse |

## Verification
A corrupted CRC register shows up in all four FCS bytes of the same frame, within four beats of the last data byte. A wrong length count shows up as a misplaced transition from data to pad, or a misplaced truncation point, within that frame. A stuck mode register alters the byte count of the following frame. A counter that counts while disabled, or wraps, diverges from a per-cycle reference count at the first affected handshake, one cycle after it.

// File: rtl/txf_pkg.sv
package txf_pkg;

    localparam int BYTE_W    = 8;
    localparam int MIN_DATA  = 60;
    localparam int FCS_BYTES = 4;
    localparam logic [31:0] CRC_POLY_REF = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED     = 32'hFFFFFFFF;

    typedef enum logic [1:0] {
        ST_DATA,
        ST_PAD,
        ST_FCS,
        ST_DROP
    } txf_state_e;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              sop;
        logic              eop;
        logic              err;
    } txf_beat_t;

    typedef struct packed {
        logic fcs;
        logic pad;
    } txf_mode_t;

    // One byte of the reflected CRC-32, least significant bit first.
    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [BYTE_W-1:0] d);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < BYTE_W; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_REF;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/txf_crc.sv
module txf_crc
    import txf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              upd,
    input  logic              start,
    input  logic [BYTE_W-1:0] din,
    input  logic [1:0]        sel,
    output logic [BYTE_W-1:0] fcs_byte
);

    logic [31:0] crc_q;
    logic [31:0] crc_inv;

    always_ff @(posedge clk) begin
        if (rst)      crc_q <= CRC_SEED;
        else if (upd) crc_q <= crc_step(start ? CRC_SEED : crc_q, din);
    end

    assign crc_inv  = ~crc_q;
    assign fcs_byte = crc_inv[{sel, 3'b000} +: BYTE_W];

endmodule

// File: rtl/txf_satcnt.sv
module txf_satcnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         ovf
);

    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else begin
            ovf <= 1'b0;
            if (inc && cnt != TOP) begin
                cnt <= cnt + 1'b1;
                ovf <= (cnt == TOP - 1'b1);
            end
        end
    end

endmodule

// File: rtl/txf_fsm.sv
module txf_fsm
    import txf_pkg::*;
#(
    parameter int MAXLEN_W = 14,
    parameter int LEN_W    = MAXLEN_W + 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_enable,
    input  logic                cfg_pad,
    input  logic                cfg_fcs,
    input  logic [MAXLEN_W-1:0] cfg_max_len,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [BYTE_W-1:0]   in_data,
    input  logic                in_sop,
    input  logic                in_eop,
    output logic                out_valid,
    input  logic                out_ready,
    output txf_beat_t           beat,
    input  logic [BYTE_W-1:0]   fcs_byte,
    output logic [1:0]          fcs_sel,
    output logic                crc_upd,
    output logic                crc_start,
    output logic [BYTE_W-1:0]   crc_din
);

    txf_state_e       state_q;
    logic [LEN_W-1:0] len_q;
    txf_mode_t        mode_q;
    logic [1:0]       idx_q;
    logic             trunc_q;

    logic             first, gate, stray, at_lim, in_last, short_f, take;
    logic [LEN_W-1:0] len_nx, lim, max_ext;
    txf_mode_t        cfg_mode, mode_now;

    always_comb begin
        first         = (len_q == '0);
        cfg_mode.fcs  = cfg_fcs;
        cfg_mode.pad  = cfg_pad & cfg_fcs;
        mode_now      = first ? cfg_mode : mode_q;
        max_ext       = LEN_W'(cfg_max_len);
        lim           = max_ext - (mode_now.fcs ? LEN_W'(FCS_BYTES) : '0);
        len_nx        = len_q + 1'b1;
        at_lim        = (len_nx >= lim);
        in_last       = in_eop || at_lim;
        short_f       = (len_nx < LEN_W'(MIN_DATA));
        stray         = first && !in_sop;
        gate          = first ? cfg_enable : 1'b1;

        in_ready  = 1'b0;
        out_valid = 1'b0;
        beat      = '0;
        case (state_q)
            ST_DATA: begin
                in_ready  = gate && (stray || out_ready);
                out_valid = gate && in_valid && !stray;
                beat.data = in_data;
                beat.sop  = first;
                beat.eop  = in_last && !mode_now.fcs;
                beat.err  = in_last && !mode_now.fcs && at_lim && !in_eop;
            end
            ST_PAD: begin
                out_valid = 1'b1;
            end
            ST_FCS: begin
                out_valid = 1'b1;
                beat.data = fcs_byte;
                beat.eop  = (idx_q == 2'd3);
                beat.err  = (idx_q == 2'd3) && trunc_q;
            end
            ST_DROP: begin
                in_ready = 1'b1;
            end
            default: ;
        endcase

        take      = out_valid && out_ready;
        crc_upd   = take && (state_q == ST_DATA || state_q == ST_PAD);
        crc_start = (state_q == ST_DATA) && first;
        crc_din   = beat.data;
        fcs_sel   = idx_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_DATA;
            len_q   <= '0;
            mode_q  <= '0;
            idx_q   <= '0;
            trunc_q <= 1'b0;
        end else begin
            case (state_q)
                ST_DATA: begin
                    if (take) begin
                        len_q <= len_nx;
                        if (first) mode_q <= mode_now;
                        if (in_last) begin
                            if (mode_now.fcs) begin
                                trunc_q <= at_lim && !in_eop;
                                idx_q   <= '0;
                                state_q <= (mode_now.pad && short_f) ? ST_PAD : ST_FCS;
                            end else begin
                                len_q <= '0;
                                if (at_lim && !in_eop) state_q <= ST_DROP;
                            end
                        end
                    end
                end
                ST_PAD: begin
                    if (take) begin
                        len_q <= len_nx;
                        if (!short_f) state_q <= ST_FCS;
                    end
                end
                ST_FCS: begin
                    if (take) begin
                        idx_q <= idx_q + 1'b1;
                        if (idx_q == 2'd3) begin
                            len_q   <= '0;
                            state_q <= trunc_q ? ST_DROP : ST_DATA;
                        end
                    end
                end
                ST_DROP: begin
                    if (in_valid && in_eop) state_q <= ST_DATA;
                end
                default: state_q <= ST_DATA;
            endcase
        end
    end

endmodule

// File: rtl/txf_shaper.sv
module txf_shaper
    import txf_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int MAXLEN_W = 14
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_enable,
    input  logic                cfg_pad,
    input  logic                cfg_fcs,
    input  logic [MAXLEN_W-1:0] cfg_max_len,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [7:0]          in_data,
    input  logic                in_sop,
    input  logic                in_eop,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [7:0]          out_data,
    output logic                out_sop,
    output logic                out_eop,
    output logic                out_err,
    output logic [CNT_W-1:0]    frame_cnt,
    output logic [CNT_W-1:0]    byte_cnt,
    output logic                ev_frame_sent,
    output logic                ev_frame_ovf,
    output logic                ev_byte_ovf
);

    localparam int LEN_W  = MAXLEN_W + 2;
    localparam int N_CNT  = 2;

    txf_beat_t         beat;
    logic [BYTE_W-1:0] fcs_byte, crc_din;
    logic [1:0]        fcs_sel;
    logic              crc_upd, crc_start;
    logic              hs, counted;
    logic [N_CNT-1:0]  cnt_inc, cnt_ovf;
    logic [CNT_W-1:0]  cnt_val [N_CNT];

    txf_fsm #(.MAXLEN_W(MAXLEN_W), .LEN_W(LEN_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .cfg_enable (cfg_enable),
        .cfg_pad    (cfg_pad),
        .cfg_fcs    (cfg_fcs),
        .cfg_max_len(cfg_max_len),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_data    (in_data),
        .in_sop     (in_sop),
        .in_eop     (in_eop),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .beat       (beat),
        .fcs_byte   (fcs_byte),
        .fcs_sel    (fcs_sel),
        .crc_upd    (crc_upd),
        .crc_start  (crc_start),
        .crc_din    (crc_din)
    );

    txf_crc u_crc (
        .clk     (clk),
        .rst     (rst),
        .upd     (crc_upd),
        .start   (crc_start),
        .din     (crc_din),
        .sel     (fcs_sel),
        .fcs_byte(fcs_byte)
    );

    assign out_data = beat.data;
    assign out_sop  = beat.sop;
    assign out_eop  = beat.eop;
    assign out_err  = beat.err;

    assign hs         = out_valid && out_ready;
    assign counted    = hs && cfg_enable;
    assign cnt_inc[0] = counted && beat.eop;
    assign cnt_inc[1] = counted;

    for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
        txf_satcnt #(.W(CNT_W)) u_cnt (
            .clk(clk),
            .rst(rst),
            .inc(cnt_inc[g]),
            .cnt(cnt_val[g]),
            .ovf(cnt_ovf[g])
        );
    end

    assign frame_cnt    = cnt_val[0];
    assign byte_cnt     = cnt_val[1];
    assign ev_frame_ovf = cnt_ovf[0];
    assign ev_byte_ovf  = cnt_ovf[1];

    always_ff @(posedge clk) begin
        if (rst) ev_frame_sent <= 1'b0;
        else     ev_frame_sent <= hs && beat.eop;
    end

endmodule

// File: rtl/txf_shaper_chk.sv
module txf_shaper_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_enable,
    input logic             out_valid,
    input logic             out_ready,
    input logic             out_sop,
    input logic             out_eop,
    input logic [CNT_W-1:0] frame_cnt,
    input logic [CNT_W-1:0] byte_cnt,
    input logic             ev_frame_sent,
    input logic             ev_frame_ovf,
    input logic             ev_byte_ovf
);

    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    p_frames_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(cfg_enable)) |-> $stable(frame_cnt));

    p_bytes_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(cfg_enable)) |-> $stable(byte_cnt));

    p_frames_no_wrap_r9: assert property (@(posedge clk) disable iff (rst)
        (frame_cnt == TOP) |=> (frame_cnt == TOP));

    p_bytes_no_wrap_r9: assert property (@(posedge clk) disable iff (rst)
        (byte_cnt == TOP) |=> (byte_cnt == TOP));

    p_frame_ovf_at_top_r10: assert property (@(posedge clk) disable iff (rst)
        ev_frame_ovf |-> (frame_cnt == TOP));

    p_byte_ovf_at_top_r10: assert property (@(posedge clk) disable iff (rst)
        ev_byte_ovf |-> (byte_cnt == TOP));

    p_byte_ovf_single_r10: assert property (@(posedge clk) disable iff (rst)
        ev_byte_ovf |=> !ev_byte_ovf);

    p_start_needs_enable_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_sop) |-> cfg_enable);

    p_sent_follows_eop_r11: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ev_frame_sent) |-> $past(out_valid && out_ready && out_eop));

endmodule

bind txf_shaper txf_shaper_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_enable   (cfg_enable),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_sop      (out_sop),
    .out_eop      (out_eop),
    .frame_cnt    (frame_cnt),
    .byte_cnt     (byte_cnt),
    .ev_frame_sent(ev_frame_sent),
    .ev_frame_ovf (ev_frame_ovf),
    .ev_byte_ovf  (ev_byte_ovf)
);

// File: tb/test_txf_shaper.sv
module test_txf_shaper;

    localparam int CNT_W = 10;
    localparam int MAXC  = (1 << CNT_W) - 1;
    localparam int NV    = 12;

    typedef struct packed {
        logic [15:0] n;
        logic [13:0] maxl;
        logic        pad;
        logic        fcs;
        logic        bp;
        logic [15:0] exp_len;
        logic        exp_err;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{16'd10,  14'd100, 1'b0, 1'b0, 1'b0, 16'd10,  1'b0},
        '{16'd10,  14'd100, 1'b0, 1'b1, 1'b0, 16'd14,  1'b0},
        '{16'd10,  14'd100, 1'b1, 1'b1, 1'b0, 16'd64,  1'b0},
        '{16'd10,  14'd100, 1'b1, 1'b0, 1'b0, 16'd10,  1'b0},
        '{16'd60,  14'd100, 1'b1, 1'b1, 1'b0, 16'd64,  1'b0},
        '{16'd61,  14'd100, 1'b1, 1'b1, 1'b0, 16'd65,  1'b0},
        '{16'd120, 14'd100, 1'b0, 1'b0, 1'b0, 16'd100, 1'b1},
        '{16'd120, 14'd100, 1'b0, 1'b1, 1'b0, 16'd100, 1'b1},
        '{16'd100, 14'd100, 1'b0, 1'b0, 1'b0, 16'd100, 1'b0},
        '{16'd96,  14'd100, 1'b0, 1'b1, 1'b0, 16'd100, 1'b0},
        '{16'd1,   14'd100, 1'b1, 1'b1, 1'b1, 16'd64,  1'b0},
        '{16'd40,  14'd100, 1'b0, 1'b1, 1'b1, 16'd44,  1'b0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_enable = 1'b1, cfg_pad = 1'b0, cfg_fcs = 1'b0;
    logic [13:0] cfg_max_len = 14'd100;
    logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [7:0] in_data = '0;
    logic out_ready = 1'b1;
    logic in_ready, out_valid, out_sop, out_eop, out_err;
    logic [7:0] out_data;
    logic [CNT_W-1:0] frame_cnt, byte_cnt;
    logic ev_frame_sent, ev_frame_ovf, ev_byte_ovf;

    int n_checks = 0, n_errors = 0;
    logic bp_on = 1'b0;
    logic [7:0] cap [256];
    logic       cap_sop [256];
    int cap_n = 0, eops = 0, ev_sent = 0, ev_fovf = 0, ev_bovf = 0, cnt_mis = 0;
    int m_frames = 0, m_bytes = 0;
    logic last_err = 1'b0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    txf_shaper #(.CNT_W(CNT_W), .MAXLEN_W(14)) i_txf_shaper (
        .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_pad(cfg_pad),
        .cfg_fcs(cfg_fcs), .cfg_max_len(cfg_max_len), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sop(out_sop), .out_eop(out_eop), .out_err(out_err),
        .frame_cnt(frame_cnt), .byte_cnt(byte_cnt), .ev_frame_sent(ev_frame_sent),
        .ev_frame_ovf(ev_frame_ovf), .ev_byte_ovf(ev_byte_ovf)
    );

    function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c ^ {24'h0, d};
        for (int b = 0; b < 8; b++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
        return r;
    endfunction

    function automatic logic [7:0] dbyte(input int seed, input int k);
        if (seed == 999) return 8'h31 + k[7:0];
        return 8'(seed * 31 + k * 7 + 1);
    endfunction

    function automatic string vec_tag(input int i);
        case (i)
            0: return "R2";
            1: return "R3";
            2, 4, 5: return "R4";
            3: return "R5";
            6, 7, 8, 9: return "R6";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    endtask

    // output monitor and reference counters (sampled away from the clock edge)
    always @(negedge clk) begin
        if (!rst) begin
            if (frame_cnt !== CNT_W'(m_frames) || byte_cnt !== CNT_W'(m_bytes)) cnt_mis++;
            if (out_valid && out_ready) begin
                if (cap_n < 256) begin
                    cap[cap_n]     = out_data;
                    cap_sop[cap_n] = out_sop;
                end
                cap_n++;
                if (cfg_enable) begin
                    if (m_bytes < MAXC) m_bytes++;
                    if (out_eop && m_frames < MAXC) m_frames++;
                end
                if (out_eop) begin
                    last_err = out_err;
                    eops++;
                end
            end
            if (ev_frame_sent) ev_sent++;
            if (ev_frame_ovf)  ev_fovf++;
            if (ev_byte_ovf)   ev_bovf++;
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            #1;
            out_ready = bp_on ? ~out_ready : 1'b1;
        end
    end

    task automatic send_frame(input int n, input int seed);
        logic ok;
        for (int k = 0; k < n; k++) begin
            in_valid = 1'b1;
            in_data  = dbyte(seed, k);
            in_sop   = (k == 0);
            in_eop   = (k == n - 1);
            do begin
                @(negedge clk);
                ok = in_ready;
                @(posedge clk);
                #1;
            end while (!ok);
        end
        in_valid = 1'b0;
        in_sop   = 1'b0;
        in_eop   = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        int e0;
        logic [CNT_W-1:0] snap;
        repeat (4) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        // R1: quiet state just after reset
        check("R1 out_valid", 64'(out_valid), 64'd0);
        check("R1 counters", {frame_cnt, byte_cnt}, '0);
        check("R1 events", {ev_frame_sent, ev_frame_ovf, ev_byte_ovf}, 3'b000);
        @(posedge clk);
        #1;

        for (int i = 0; i < NV; i++) begin
            int d, lim, padn, bad;
            logic [31:0] c, f;
            logic [7:0] e;
            cfg_pad     = VEC[i].pad;
            cfg_fcs     = VEC[i].fcs;
            cfg_max_len = VEC[i].maxl;
            bp_on       = VEC[i].bp;
            cap_n = 0;
            e0 = eops;
            send_frame(int'(VEC[i].n), i);
            wait (eops == e0 + 1);
            @(posedge clk);
            #1;
            bp_on = 1'b0;
            lim  = int'(VEC[i].maxl) - (VEC[i].fcs ? 4 : 0);
            d    = (int'(VEC[i].n) > lim) ? lim : int'(VEC[i].n);
            padn = (VEC[i].pad && VEC[i].fcs && d < 60) ? 60 - d : 0;
            c = 32'hFFFFFFFF;
            bad = 0;
            for (int j = 0; j < d; j++) begin
                e = dbyte(i, j);
                if (cap[j] !== e) bad++;
                c = ref_crc(c, e);
            end
            for (int j = 0; j < padn; j++) begin
                if (cap[d + j] !== 8'h00) bad++;
                c = ref_crc(c, 8'h00);
            end
            f = ~c;
            if (VEC[i].fcs)
                for (int b = 0; b < 4; b++)
                    if (cap[d + padn + b] !== f[8*b +: 8]) bad++;
            for (int j = 0; j < cap_n && j < 256; j++)
                if (cap_sop[j] !== (j == 0)) bad++;
            check({vec_tag(i), " length"}, 64'(cap_n), 64'(VEC[i].exp_len));
            check({vec_tag(i), " error flag"}, 64'(last_err), 64'(VEC[i].exp_err));
            check({vec_tag(i), " content"}, 64'(bad), 64'd0);
        end

        // R3: known CRC-32 of ASCII "123456789"
        cfg_pad = 1'b0; cfg_fcs = 1'b1;
        cap_n = 0; e0 = eops;
        send_frame(9, 999);
        wait (eops == e0 + 1);
        @(posedge clk); #1;
        check("R3 check value", {cap[12], cap[11], cap[10], cap[9]}, 64'hCBF43926);

        // R2: a beat without start marker between packets is dropped
        cfg_fcs = 1'b0;
        cap_n = 0; e0 = eops;
        in_valid = 1'b1; in_sop = 1'b0; in_eop = 1'b1; in_data = 8'hAA;
        @(posedge clk); #1;
        in_valid = 1'b0; in_eop = 1'b0;
        send_frame(5, 7);
        wait (eops == e0 + 1);
        @(posedge clk); #1;
        check("R2 stray length", 64'(cap_n), 64'd5);
        check("R2 stray first byte", 64'(cap[0]), 64'(dbyte(7, 0)));

        // R7: disabling mid-packet finishes it; next packet is held
        cfg_fcs = 1'b1;
        cap_n = 0; e0 = eops;
        fork
            send_frame(30, 5);
        join_none
        repeat (10) @(posedge clk);
        #1;
        cfg_enable = 1'b0;
        @(negedge clk);
        snap = byte_cnt;
        wait (eops == e0 + 1);
        repeat (3) @(posedge clk);
        #1;
        check("R7 finished frame length", 64'(cap_n), 64'd34);
        check("R8 bytes frozen while disabled", 64'(byte_cnt), 64'(snap));
        cap_n = 0;
        fork
            send_frame(8, 6);
        join_none
        repeat (20) @(posedge clk);
        @(negedge clk);
        check("R7 held in_ready", 64'(in_ready), 64'd0);
        check("R7 held output", {out_valid, 8'(cap_n)}, '0);
        @(posedge clk); #1;
        cfg_enable = 1'b1;
        wait (eops == e0 + 2);
        repeat (2) @(posedge clk);
        #1;
        check("R7 resumed frame length", 64'(cap_n), 64'd12);

        // R9 R10: drive both counters to saturation
        cfg_fcs = 1'b0;
        for (int i = 0; i < 1100; i++) send_frame(1, i);
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R9 frame count saturated", 64'(frame_cnt), 64'(MAXC));
        check("R9 byte count saturated", 64'(byte_cnt), 64'(MAXC));
        check("R10 frame overflow pulses", 64'(ev_fovf), 64'd1);
        check("R10 byte overflow pulses", 64'(ev_bovf), 64'd1);
        check("R8 counters follow reference", 64'(cnt_mis), 64'd0);
        check("R11 frame-sent pulses", 64'(ev_sent), 64'(eops));
        done = 1'b1;
        finish_run();
    end

endmodule